// File: doc/BRIEF.md
# Boot-Overlay System Address Decoder with Interrupt Level Merge

This block sits between a big-endian CPU bus and the targets behind it. For every access it receives an address, an access width code and a direction flag. It answers in the same cycle with a one-hot target select and the target-local register offset. One clock later it raises a single-cycle bus-error pulse when the access was illegal. The targets are RAM, ROM, two wide peripheral windows and eight narrow peripheral windows. The narrow windows sit on odd byte lanes, so their local offsets are halved.

After reset, a boot overlay is armed. While it is armed, the only legal accesses are the two 32-bit reset-vector reads at address 0 and address 4. Both are steered into ROM. The read of address 4 disarms the overlay, and from then on the normal map applies. Any other access during the overlay is a bus error.

The block also collects one interrupt request line per peripheral window. Each window has a fixed priority level. The highest level among the asserted lines is registered and presented to the CPU as a 3-bit level.

Top module: `sysdec_top`

## Requirements
- R1: A read or write that fits entirely inside 0x000000..0x0FFFFF asserts tgt_sel[0] (RAM), with tgt_off equal to the address.
- R2: A read that fits inside 0x100000..0x10FFFF asserts tgt_sel[1] (ROM), with tgt_off equal to address minus 0x100000. Any write there is a bus error, and tgt_sel[1] is never high during a write.
- R3: Wide window k (k = 0,1) covers 0x180000 + k*0x80000 for 0x80000 bytes. An access whose start address lies inside it asserts tgt_sel[2+k], with offset equal to address minus base.
- R4: Narrow window j (j = 0..7) covers 0x3A0001 + j*0x4000 for 0x4000 bytes, with the start included and the end excluded. An access starting there asserts tgt_sel[4+j], with offset (address minus base) divided by two. 0x3A0000 and 0x3C0001 hit no window.
- R5: For RAM and ROM, the last byte (address + size - 1) must also lie inside the region. Otherwise the access is a bus error.
- R6: After reset, a 32-bit read (acc_size 2) of address 0 or 4 selects ROM with tgt_off equal to the address. The read of address 4 disarms the overlay, after which address 0 decodes as RAM. The overlay is not armed again without reset.
- R7: While the overlay is armed, any other access (other width, write, other address) is a bus error with all selects low, and the overlay stays armed.
- R8: An address that hits no region, or acc_size code 3, is a bus error. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R9: tgt_sel has at most one bit high, and is all zero for an erroring access. bus_err is high for exactly the one clock following an erroring valid access, and low after a legal one or an idle cycle.
- R10: irq_level is registered. One clock after irq_req changes, it equals the highest fixed level among asserted requests. Window 2 (bit 4 of irq_req, base 0x3A8001) has level 5, and every other window has level 0.
- R11: Reset clears bus_err and irq_level and arms the overlay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Byte address of the access |
| acc_size | input | 2 | Width code: 0 byte, 1 half, 2 word, 3 illegal |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| irq_req | input | 10 | One request line per peripheral window, bit k for tgt_sel[2+k] |
| tgt_sel | output | 12 | One-hot target select: RAM, ROM, wide windows, narrow windows |
| tgt_off | output | 24 | Target-local offset |
| bus_err | output | 1 | Registered one-cycle error pulse |
| irq_level | output | 3 | Registered CPU interrupt level |

## Verification
The overlay is the hardest state to reach from the ports. It exists only between a reset and the second vector fetch. Every rejected access must leave it armed, while a single correct read disarms it for good. The stimulus therefore opens with the illegal accesses, a byte read and a word write at address 0, and follows them with the two vector reads. It then shows that address 0 has moved to RAM. A second reset later in the run checks that the overlay is armed again.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int unsigned RAM_BASE    = 32'h0000_0000;
  localparam int unsigned RAM_SPAN    = 32'h0010_0000;
  localparam int unsigned ROM_BASE    = 32'h0010_0000;
  localparam int unsigned ROM_SPAN    = 32'h0001_0000;
  localparam int unsigned WIDE_BASE   = 32'h0018_0000;
  localparam int unsigned WIDE_SPAN   = 32'h0008_0000;
  localparam int unsigned NARROW_BASE = 32'h003A_0001;
  localparam int unsigned NARROW_SPAN = 32'h0000_4000;
  localparam int unsigned VEC_FIRST   = 32'h0000_0000;
  localparam int unsigned VEC_LAST    = 32'h0000_0004;
endpackage

// File: rtl/sysdec_window.sv
module sysdec_window #(
  parameter int          ADDR_W   = 24,
  parameter int unsigned BASE     = 0,
  parameter int unsigned SPAN     = 1,
  parameter bit          FIT      = 1'b0,
  parameter bit          WRITABLE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   last,
  input  logic              wr,
  output logic              hit,
  output logic [ADDR_W-1:0] off
);
  localparam logic [ADDR_W:0] LO    = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] SPN   = (ADDR_W+1)'(SPAN);
  localparam bit              HALVE = BASE[0];

  logic [ADDR_W:0] diff;
  logic [ADDR_W:0] last_diff;
  logic            in_rng;
  logic            fit_ok;
  logic            wr_ok;

  // Wrapping subtraction: an address below the base yields a huge difference.
  always_comb begin
    diff      = {1'b0, addr} - LO;
    last_diff = last - LO;
    in_rng    = diff < SPN;
    fit_ok    = FIT ? (last_diff < SPN) : 1'b1;
    wr_ok     = WRITABLE ? 1'b1 : !wr;
    hit       = in_rng && fit_ok && wr_ok;
    off       = HALVE ? diff[ADDR_W:1] : diff[ADDR_W-1:0];
  end

  // R4 / R1: a hit always yields an offset inside the window span.
  always_comb begin
    if (hit) begin
      assert_off_in_span_R4: assert ({1'b0, off} < SPN);
    end
  end
endmodule

// File: rtl/sysdec_overlay.sv
module sysdec_overlay (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic active
);
  logic act_q;
  logic act_n;
  logic act_en;

  always_comb begin
    act_en = clear && act_q;
    act_n  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
    end else if (act_en) begin
      act_q <= act_n;
    end
  end

  assign active = act_q;

  // R6: once disarmed the overlay stays off until the next reset.
  assert_ovl_stays_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |=> !act_q);
endmodule

// File: rtl/sysdec_irq.sv
module sysdec_irq #(
  parameter int NSRC       = 10,
  parameter int LVL_W      = 3,
  parameter int SERIAL_IDX = 4,
  parameter int SERIAL_LVL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  output logic [LVL_W-1:0] level
);
  function automatic logic [LVL_W-1:0] lvl_of(input int idx);
    return (idx == SERIAL_IDX) ? LVL_W'(SERIAL_LVL) : '0;
  endfunction

  logic [LVL_W-1:0] max_n;
  logic [LVL_W-1:0] lvl_q;

  always_comb begin
    max_n = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (lvl_of(i) > max_n)) begin
        max_n = lvl_of(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= max_n;
    end
  end

  assign level = lvl_q;

  // R10: no request lines asserted means level 0 on the next clock.
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (level == '0));
endmodule

// File: rtl/sysdec_top.sv
module sysdec_top
  import sysdec_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int NUM_WIDE   = 2,
  parameter int NUM_NARROW = 8,
  parameter int LVL_W      = 3,
  parameter int SERIAL_WIN = 4,
  parameter int SERIAL_LVL = 5,
  localparam int NWIN      = NUM_WIDE + NUM_NARROW,
  localparam int NTGT      = 2 + NWIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic [NWIN-1:0]   irq_req,
  output logic [NTGT-1:0]   tgt_sel,
  output logic [ADDR_W-1:0] tgt_off,
  output logic              bus_err,
  output logic [LVL_W-1:0]  irq_level
);
  localparam int RAM_IDX = 0;
  localparam int ROM_IDX = 1;
  localparam int WIN_IDX = 2;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1;
  logic rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_int_n <= rst_s1;
    end
  end

  // Access extent.
  logic [ADDR_W:0] last_addr;
  logic [2:0]      nbytes;
  always_comb begin
    case (acc_size_e'(acc_size))
      SZ_BYTE: nbytes = 3'd1;
      SZ_HALF: nbytes = 3'd2;
      SZ_WORD: nbytes = 3'd4;
      default: nbytes = 3'd1;
    endcase
    last_addr = {1'b0, acc_addr} + (ADDR_W+1)'(nbytes) - (ADDR_W+1)'(1);
  end

  // Region comparators.
  logic [NTGT-1:0]   hit_vec;
  logic [ADDR_W-1:0] off_arr [NTGT];

  sysdec_window #(.ADDR_W(ADDR_W), .BASE(RAM_BASE), .SPAN(RAM_SPAN),
                  .FIT(1'b1), .WRITABLE(1'b1)) u_ram (
    .addr(acc_addr), .last(last_addr), .wr(acc_write),
    .hit(hit_vec[RAM_IDX]), .off(off_arr[RAM_IDX]));

  sysdec_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .SPAN(ROM_SPAN),
                  .FIT(1'b1), .WRITABLE(1'b0)) u_rom (
    .addr(acc_addr), .last(last_addr), .wr(acc_write),
    .hit(hit_vec[ROM_IDX]), .off(off_arr[ROM_IDX]));

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam bit          IS_WIDE = (k < NUM_WIDE);
    localparam int unsigned W_BASE  = IS_WIDE ? (WIDE_BASE + k * WIDE_SPAN)
                                              : (NARROW_BASE + (k - NUM_WIDE) * NARROW_SPAN);
    localparam int unsigned W_SPAN  = IS_WIDE ? WIDE_SPAN : NARROW_SPAN;
    sysdec_window #(.ADDR_W(ADDR_W), .BASE(W_BASE), .SPAN(W_SPAN),
                    .FIT(1'b0), .WRITABLE(1'b1)) u_win (
      .addr(acc_addr), .last(last_addr), .wr(acc_write),
      .hit(hit_vec[WIN_IDX+k]), .off(off_arr[WIN_IDX+k]));
  end

  // Boot overlay.
  logic ovl_active;
  logic ovl_vec_rd;
  logic ovl_clear;

  always_comb begin
    ovl_vec_rd = ovl_active && acc_valid && !acc_write &&
                 (acc_size_e'(acc_size) == SZ_WORD) &&
                 ((acc_addr == ADDR_W'(VEC_FIRST)) || (acc_addr == ADDR_W'(VEC_LAST)));
    ovl_clear  = ovl_vec_rd && (acc_addr == ADDR_W'(VEC_LAST));
  end

  sysdec_overlay u_ovl (
    .clk(clk), .rst_n(rst_int_n), .clear(ovl_clear), .active(ovl_active));

  // Target selection, next-state of the error flag.
  logic [NTGT-1:0]   sel_c;
  logic [ADDR_W-1:0] off_c;
  logic              err_c;

  always_comb begin
    sel_c = '0;
    off_c = '0;
    err_c = 1'b0;
    if (acc_valid) begin
      if (ovl_active) begin
        if (ovl_vec_rd) begin
          sel_c[ROM_IDX] = 1'b1;
          off_c          = acc_addr;
        end else begin
          err_c = 1'b1;
        end
      end else if ((acc_size_e'(acc_size) == SZ_BAD) || (hit_vec == '0)) begin
        err_c = 1'b1;
      end else begin
        for (int i = NTGT - 1; i >= 0; i--) begin
          if (hit_vec[i]) begin
            sel_c    = '0;
            sel_c[i] = 1'b1;
            off_c    = off_arr[i];
          end
        end
      end
    end
  end

  logic err_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_c;
    end
  end

  assign tgt_sel = sel_c;
  assign tgt_off = off_c;
  assign bus_err = err_q;

  sysdec_irq #(.NSRC(NWIN), .LVL_W(LVL_W), .SERIAL_IDX(SERIAL_WIN),
               .SERIAL_LVL(SERIAL_LVL)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .req(irq_req), .level(irq_level));

  // R9: selects are one-hot or empty.
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(tgt_sel));
  // R9: an unselected valid access raises the error pulse next cycle.
  assert_err_follows_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && (tgt_sel == '0)) |=> bus_err);
  // R9: a selected access never raises the error pulse.
  assert_no_err_on_sel_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tgt_sel != '0) |=> !bus_err);
  // R2: ROM is never selected for a write.
  assert_rom_readonly_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_write |-> !tgt_sel[ROM_IDX]);
endmodule

// File: tb/sysdec_top_tb.sv
`timescale 1ns/100ps
module sysdec_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [23:0] acc_addr;
  logic [1:0]  acc_size;
  logic        acc_write;
  logic [9:0]  irq_req;
  logic [11:0] tgt_sel;
  logic [23:0] tgt_off;
  logic        bus_err;
  logic [2:0]  irq_level;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sysdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .irq_req(irq_req),
    .tgt_sel(tgt_sel), .tgt_off(tgt_off), .bus_err(bus_err), .irq_level(irq_level));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_addr = '0; acc_size = 2'd0; acc_write = 1'b0; irq_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One access: selects/offset in the same cycle, error one clock later.
  task automatic acc(input string req, input logic [23:0] a, input logic [1:0] sz,
                     input logic wr, input logic [11:0] exp_sel,
                     input logic [23:0] exp_off, input logic exp_err);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr;
    #1;
    chk({req, " sel"}, 32'(tgt_sel), 32'(exp_sel));
    if (exp_sel != '0) chk({req, " off"}, 32'(tgt_off), 32'(exp_off));
    @(posedge clk);
    #1;
    chk({req, " err"}, 32'(bus_err), 32'(exp_err));
    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk);
    #1;
    chk({req, " err pulse ends"}, 32'(bus_err), 32'd0);
  endtask

  task automatic t_reset_state();
    #1;
    chk("R11 bus_err at reset", 32'(bus_err), 32'd0);
    chk("R11 irq_level at reset", 32'(irq_level), 32'd0);
    chk("R11 no select idle", 32'(tgt_sel), 32'd0);
  endtask

  task automatic t_overlay_reject();
    acc("R7 byte read during overlay", 24'h000000, 2'd0, 1'b0, 12'h000, 24'h0, 1'b1);
    acc("R7 word write during overlay", 24'h000000, 2'd2, 1'b1, 12'h000, 24'h0, 1'b1);
    acc("R7 word read other addr", 24'h000008, 2'd2, 1'b0, 12'h000, 24'h0, 1'b1);
  endtask

  task automatic t_overlay_boot();
    acc("R6 vector 0 to ROM", 24'h000000, 2'd2, 1'b0, 12'h002, 24'h000000, 1'b0);
    acc("R6 vector 0 again", 24'h000000, 2'd2, 1'b0, 12'h002, 24'h000000, 1'b0);
    acc("R6 vector 4 to ROM", 24'h000004, 2'd2, 1'b0, 12'h002, 24'h000004, 1'b0);
    acc("R6 addr 0 now RAM", 24'h000000, 2'd2, 1'b0, 12'h001, 24'h000000, 1'b0);
  endtask

  task automatic t_ram_rom();
    acc("R1 RAM byte write", 24'h0ABCDE, 2'd0, 1'b1, 12'h001, 24'h0ABCDE, 1'b0);
    acc("R1 RAM word read at top", 24'h0FFFFC, 2'd2, 1'b0, 12'h001, 24'h0FFFFC, 1'b0);
    acc("R2 ROM half read", 24'h100010, 2'd1, 1'b0, 12'h002, 24'h000010, 1'b0);
    acc("R2 ROM byte write", 24'h100010, 2'd0, 1'b1, 12'h000, 24'h0, 1'b1);
    acc("R5 RAM word crosses end", 24'h0FFFFE, 2'd2, 1'b0, 12'h000, 24'h0, 1'b1);
    acc("R5 ROM half crosses end", 24'h10FFFF, 2'd1, 1'b0, 12'h000, 24'h0, 1'b1);
    acc("R5 ROM last byte fits", 24'h10FFFF, 2'd0, 1'b0, 12'h002, 24'h00FFFF, 1'b0);
  endtask

  task automatic t_windows();
    acc("R3 wide0", 24'h180010, 2'd1, 1'b0, 12'h004, 24'h000010, 1'b0);
    acc("R3 wide1 last", 24'h27FFFF, 2'd0, 1'b1, 12'h008, 24'h07FFFF, 1'b0);
    acc("R4 narrow0 base", 24'h3A0001, 2'd0, 1'b0, 12'h010, 24'h000000, 1'b0);
    acc("R4 narrow2 halved", 24'h3A8021, 2'd0, 1'b1, 12'h040, 24'h000010, 1'b0);
    acc("R4 narrow7 last", 24'h3C0000, 2'd0, 1'b0, 12'h800, 24'h001FFF, 1'b0);
    acc("R4 below narrow0", 24'h3A0000, 2'd0, 1'b0, 12'h000, 24'h0, 1'b1);
    acc("R4 past narrow7", 24'h3C0001, 2'd0, 1'b0, 12'h000, 24'h0, 1'b1);
  endtask

  task automatic t_errors();
    acc("R8 gap after wide1", 24'h280000, 2'd0, 1'b0, 12'h000, 24'h0, 1'b1);
    acc("R8 gap after ROM", 24'h110000, 2'd1, 1'b1, 12'h000, 24'h0, 1'b1);
    acc("R8 size code 3", 24'h050000, 2'd3, 1'b0, 12'h000, 24'h0, 1'b1);
  endtask

  task automatic t_irq();
    @(negedge clk);
    irq_req = 10'b00_0001_0001;
    #1;
    chk("R10 level not yet updated", 32'(irq_level), 32'd0);
    @(posedge clk); #1;
    chk("R10 serial level wins", 32'(irq_level), 32'd5);
    @(negedge clk);
    irq_req = 10'b10_0000_0001;
    @(posedge clk); #1;
    chk("R10 level-0 sources only", 32'(irq_level), 32'd0);
    @(negedge clk);
    irq_req = 10'b00_0001_0000;
    @(posedge clk); #1;
    chk("R10 serial alone", 32'(irq_level), 32'd5);
    @(negedge clk);
    irq_req = '0;
    @(posedge clk); #1;
    chk("R10 cleared", 32'(irq_level), 32'd0);
  endtask

  task automatic t_rearm();
    @(negedge clk);
    irq_req = 10'b00_0001_0000;
    @(posedge clk); #1;
    do_reset();
    chk("R11 irq_level after reset", 32'(irq_level), 32'd0);
    chk("R11 bus_err after reset", 32'(bus_err), 32'd0);
    acc("R11 overlay rearmed", 24'h000000, 2'd2, 1'b0, 12'h002, 24'h000000, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_addr = '0; acc_size = 2'd0; acc_write = 1'b0; irq_req = '0;
    do_reset();
    t_reset_state();
    t_overlay_reject();
    t_overlay_boot();
    t_ram_rom();
    t_windows();
    t_errors();
    t_irq();
    t_rearm();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule